// File: doc/BRIEF.md
# Operand Resolver with Constant Generator

This block turns the addressing fields of a decoded two-operand instruction into operand values for a 16-bit microcontroller datapath. After a one-cycle `start` it latches the source mode and register, the destination mode and register, the byte flag and the address of the first word after the opcode. It then walks a small sequence. It reads registers through a combinational register-file port and fetches index words and operands through a one-outstanding request/valid memory port. It finishes with a one-cycle `done`. At that point the source value, the destination value, the destination effective address and any register post-increment are on its outputs, together with the advanced program counter.

Registers 0, 2 and 3 get special decoding on the source side. With register 0 the indexed mode addresses relative to the program counter and the autoincrement mode reads an immediate word. Register 2 in indexed mode is an absolute address. Register 2 in modes 2 and 3, and register 3 in every mode, produce constants with no memory traffic. The ALU and the write-back of results or increments are outside this block.

Top module: `opd_resolver`

## Requirements
- R1: Source mode 0 on a general register returns its contents. With register 0 it returns the current program counter.
- R2: Source mode 1 fetches an index word at the program counter and advances it by 2. The operand is the memory word at base plus index. The base is the register, except register 0, whose base is the address of the index word, and register 2, whose base is 0.
- R3: Source mode 2 returns the memory word at the address held in the register and requests no post-increment.
- R4: Source mode 3 on a register other than 0, 2 or 3 reads at the register's address. It reports `inc_en`=1 with `inc_reg` set to that register and `inc_val` set to the register plus 1 (byte) or plus 2 (word).
- R5: Source mode 3 on register 0 returns the word at the program counter as an immediate. It advances the program counter by 2 even in byte mode and reports no post-increment.
- R6: Register 2 in mode 2 yields 4 and in mode 3 yields 8, with no memory request and no program-counter change.
- R7: Register 3 in modes 0, 1, 2 and 3 yields 0, 1, 2 and all ones (0x00FF in byte mode), with no memory request and no index word.
- R8: Destination mode 0 returns the register contents (the program counter for register 0), with `dst_is_mem`=0 and `dst_addr`=0. Destination mode 1 fetches its index word after any source index word and advances the program counter by 2. It sets `dst_addr` to base plus index, with the same base rules as R2, and `dst_val` to the memory word there, with `dst_is_mem`=1.
- R9: In byte mode (`byte_op`=1) every operand is zero-extended from 8 bits. A memory operand takes the upper byte of the aligned word when the address is odd and the lower byte when it is even.
- R10: When the source post-increments a register that is also the destination register, the destination uses the incremented value.
- R11: `start` is taken only while `busy` is 0. `done` is high for exactly one cycle and the results hold until the next start. Each memory read is a one-cycle `mem_req` pulse, and no new pulse is issued before `mem_rvalid` has answered the previous one.
- R12: After reset `busy`, `done`, `mem_req` and `inc_en` are 0, and all value outputs and `pc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving the presented fields |
| src_mode | input | 2 | Source addressing mode |
| src_reg | input | 4 | Source register number |
| dst_mode | input | 1 | Destination addressing mode |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | 1 = byte operation, 0 = word |
| pc_in | input | 16 | Address of the word following the opcode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 16 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read word (aligned) |
| src_val | output | 16 | Resolved source operand |
| dst_val | output | 16 | Resolved destination operand |
| dst_addr | output | 16 | Destination effective address |
| dst_is_mem | output | 1 | Destination lies in memory |
| inc_en | output | 1 | A register post-increment is due |
| inc_reg | output | 4 | Register to post-increment |
| inc_val | output | 16 | New value for that register |
| pc_out | output | 16 | Program counter after all fetches |

## Verification
Two functions collide when a source autoincrement and the destination base read both target the same register. The incremented value must then reach the destination address computation in the cycle right after it is produced. A second collision occurs when the program counter is both advanced by the source index or immediate fetch and read as the destination base. Directed operations set `dst_reg` equal to `src_reg` in source mode 3 with an indexed destination, and use register 0 on both sides. Random operations also hit these cases. In each case `dst_addr`, `inc_val` and `pc_out` are compared against a bench model that applies the increment and the program-counter steps in program order.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int unsigned REG_PC  = 0;
  localparam int unsigned REG_ABS = 2;
  localparam int unsigned REG_CG  = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRC,
    ST_SIDX,
    ST_SOPW,
    ST_DST,
    ST_DIDX,
    ST_DOPW,
    ST_FIN
  } opd_state_e;
endpackage

// File: rtl/opd_cgen.sv
module opd_cgen
  import opd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic [RAW-1:0] reg_num,
  input  logic [1:0]     mode,
  output logic           hit,
  output logic [DW-1:0]  value
);
  always_comb begin
    hit   = 1'b0;
    value = '0;
    if (reg_num == RAW'(REG_CG)) begin
      hit = 1'b1;
      case (mode)
        2'b00:   value = '0;
        2'b01:   value = DW'(1);
        2'b10:   value = DW'(2);
        default: value = '1;
      endcase
    end else if (reg_num == RAW'(REG_ABS) && mode[1]) begin
      hit   = 1'b1;
      value = mode[0] ? DW'(8) : DW'(4);
    end
  end
endmodule

// File: rtl/opd_incr.sv
module opd_incr #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base,
  input  logic          byte_op,
  input  logic          is_pc,
  output logic [DW-1:0] next
);
  localparam int WSTEP = DW / 8;

  assign next = base + ((byte_op && !is_pc) ? DW'(1) : DW'(WSTEP));
endmodule

// File: rtl/opd_fetch.sv
module opd_fetch
  import opd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     src_mode,
  input  logic [RAW-1:0] src_reg,
  input  logic           dst_mode,
  input  logic [RAW-1:0] dst_reg,
  input  logic           byte_op,
  input  logic [DW-1:0]  pc_in,
  output logic           busy,
  output logic           done,
  output logic [RAW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [RAW-1:0] cg_reg,
  output logic [1:0]     cg_mode,
  input  logic           cg_hit,
  input  logic [DW-1:0]  cg_val,
  output logic [DW-1:0]  inc_base,
  output logic           inc_is_pc,
  output logic           inc_byte,
  input  logic [DW-1:0]  inc_next,
  output logic [DW-1:0]  src_val,
  output logic [DW-1:0]  dst_val,
  output logic [DW-1:0]  dst_addr,
  output logic           dst_is_mem,
  output logic           inc_en,
  output logic [RAW-1:0] inc_reg,
  output logic [DW-1:0]  inc_val,
  output logic [DW-1:0]  pc_out
);
  localparam int HW    = DW / 2;
  localparam int WSTEP = DW / 8;

  opd_state_e     state_q;
  logic [1:0]     sm_q;
  logic [RAW-1:0] sr_q;
  logic           dm_q;
  logic [RAW-1:0] dr_q;
  logic           byte_q;
  logic [DW-1:0]  pc_q;
  logic [DW-1:0]  base_q;
  logic [DW-1:0]  src_reg_val;
  logic [DW-1:0]  dst_base;

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] v, input logic b);
    narrow = b ? {{(DW-HW){1'b0}}, v[HW-1:0]} : v;
  endfunction

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] w, input logic odd,
                                         input logic b);
    if (!b)       pick = w;
    else if (odd) pick = {{(DW-HW){1'b0}}, w[DW-1:HW]};
    else          pick = {{(DW-HW){1'b0}}, w[HW-1:0]};
  endfunction

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign pc_out    = pc_q;
  assign cg_reg    = sr_q;
  assign cg_mode   = sm_q;
  assign rf_raddr  = (state_q == ST_DST) ? dr_q : sr_q;
  assign src_reg_val = (sr_q == RAW'(REG_PC)) ? pc_q : rf_rdata;
  assign inc_base  = src_reg_val;
  assign inc_is_pc = (sr_q == RAW'(REG_PC));
  assign inc_byte  = byte_q;

  always_comb begin
    if (dr_q == RAW'(REG_PC))                dst_base = pc_q;
    else if (inc_en && inc_reg == dr_q)      dst_base = inc_val;
    else                                     dst_base = rf_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sm_q       <= '0;
      sr_q       <= '0;
      dm_q       <= 1'b0;
      dr_q       <= '0;
      byte_q     <= 1'b0;
      pc_q       <= '0;
      base_q     <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      src_val    <= '0;
      dst_val    <= '0;
      dst_addr   <= '0;
      dst_is_mem <= 1'b0;
      inc_en     <= 1'b0;
      inc_reg    <= '0;
      inc_val    <= '0;
    end else begin
      mem_req <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            sm_q       <= src_mode;
            sr_q       <= src_reg;
            dm_q       <= dst_mode;
            dr_q       <= dst_reg;
            byte_q     <= byte_op;
            pc_q       <= pc_in;
            inc_en     <= 1'b0;
            dst_is_mem <= 1'b0;
            dst_addr   <= '0;
            state_q    <= ST_SRC;
          end
        end
        ST_SRC: begin
          if (cg_hit) begin
            src_val <= narrow(cg_val, byte_q);
            state_q <= ST_DST;
          end else begin
            case (sm_q)
              2'b00: begin
                src_val <= narrow(src_reg_val, byte_q);
                state_q <= ST_DST;
              end
              2'b01: begin
                mem_req  <= 1'b1;
                mem_addr <= pc_q;
                base_q   <= (sr_q == RAW'(REG_ABS)) ? '0 : src_reg_val;
                pc_q     <= pc_q + DW'(WSTEP);
                state_q  <= ST_SIDX;
              end
              2'b10: begin
                mem_req  <= 1'b1;
                mem_addr <= src_reg_val;
                state_q  <= ST_SOPW;
              end
              default: begin
                mem_req  <= 1'b1;
                mem_addr <= src_reg_val;
                if (sr_q == RAW'(REG_PC)) begin
                  pc_q <= inc_next;
                end else begin
                  inc_en  <= 1'b1;
                  inc_reg <= sr_q;
                  inc_val <= inc_next;
                end
                state_q <= ST_SOPW;
              end
            endcase
          end
        end
        ST_SIDX: begin
          if (mem_rvalid) begin
            mem_req  <= 1'b1;
            mem_addr <= base_q + mem_rdata;
            state_q  <= ST_SOPW;
          end
        end
        ST_SOPW: begin
          if (mem_rvalid) begin
            src_val <= pick(mem_rdata, mem_addr[0], byte_q);
            state_q <= ST_DST;
          end
        end
        ST_DST: begin
          if (!dm_q) begin
            dst_val    <= narrow(dst_base, byte_q);
            dst_addr   <= '0;
            dst_is_mem <= 1'b0;
            state_q    <= ST_FIN;
          end else begin
            mem_req    <= 1'b1;
            mem_addr   <= pc_q;
            base_q     <= (dr_q == RAW'(REG_ABS)) ? '0 : dst_base;
            pc_q       <= pc_q + DW'(WSTEP);
            dst_is_mem <= 1'b1;
            state_q    <= ST_DIDX;
          end
        end
        ST_DIDX: begin
          if (mem_rvalid) begin
            mem_req  <= 1'b1;
            mem_addr <= base_q + mem_rdata;
            dst_addr <= base_q + mem_rdata;
            state_q  <= ST_DOPW;
          end
        end
        ST_DOPW: begin
          if (mem_rvalid) begin
            dst_val <= pick(mem_rdata, mem_addr[0], byte_q);
            state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: each read request is a single-cycle pulse
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6 / R7: a constant from the generator never produces memory traffic
  p_cst_nomem_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SRC && cg_hit) |=> !mem_req);

  // R4: the reported increment is one operand size above the register read
  p_inc_step_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(inc_en) |-> (inc_val == $past(rf_rdata) +
                       ($past(byte_q) ? DW'(1) : DW'(WSTEP))));

  // R9: byte results carry no upper-half bits
  p_byte_zext_r9: assert property (@(posedge clk) disable iff (rst)
    (done && byte_q) |-> (src_val[DW-1:HW] == '0 && dst_val[DW-1:HW] == '0));
endmodule

// File: rtl/opd_resolver.sv
module opd_resolver
  import opd_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     src_mode,
  input  logic [RAW-1:0] src_reg,
  input  logic           dst_mode,
  input  logic [RAW-1:0] dst_reg,
  input  logic           byte_op,
  input  logic [DW-1:0]  pc_in,
  output logic           busy,
  output logic           done,
  output logic [RAW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  src_val,
  output logic [DW-1:0]  dst_val,
  output logic [DW-1:0]  dst_addr,
  output logic           dst_is_mem,
  output logic           inc_en,
  output logic [RAW-1:0] inc_reg,
  output logic [DW-1:0]  inc_val,
  output logic [DW-1:0]  pc_out
);
  logic [RAW-1:0] cg_reg;
  logic [1:0]     cg_mode;
  logic           cg_hit;
  logic [DW-1:0]  cg_val;
  logic [DW-1:0]  inc_base;
  logic           inc_is_pc;
  logic           inc_byte;
  logic [DW-1:0]  inc_next;

  opd_cgen #(.DW(DW), .RAW(RAW)) u_cgen (
    .reg_num (cg_reg),
    .mode    (cg_mode),
    .hit     (cg_hit),
    .value   (cg_val)
  );

  opd_incr #(.DW(DW)) u_incr (
    .base    (inc_base),
    .byte_op (inc_byte),
    .is_pc   (inc_is_pc),
    .next    (inc_next)
  );

  opd_fetch #(.DW(DW), .RAW(RAW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_mode   (src_mode),
    .src_reg    (src_reg),
    .dst_mode   (dst_mode),
    .dst_reg    (dst_reg),
    .byte_op    (byte_op),
    .pc_in      (pc_in),
    .busy       (busy),
    .done       (done),
    .rf_raddr   (rf_raddr),
    .rf_rdata   (rf_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .cg_reg     (cg_reg),
    .cg_mode    (cg_mode),
    .cg_hit     (cg_hit),
    .cg_val     (cg_val),
    .inc_base   (inc_base),
    .inc_is_pc  (inc_is_pc),
    .inc_byte   (inc_byte),
    .inc_next   (inc_next),
    .src_val    (src_val),
    .dst_val    (dst_val),
    .dst_addr   (dst_addr),
    .dst_is_mem (dst_is_mem),
    .inc_en     (inc_en),
    .inc_reg    (inc_reg),
    .inc_val    (inc_val),
    .pc_out     (pc_out)
  );

  // R5 / R7: neither the program counter nor the constant register is post-incremented
  p_noinc_special_r7: assert property (@(posedge clk) disable iff (rst)
    (done && inc_en) |-> (inc_reg != RAW'(REG_PC) && inc_reg != RAW'(REG_CG)));

  // R11: completion only while a sequence is in flight
  p_done_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

// File: tb/tb_opd_resolver.sv
module tb_opd_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  src_mode = '0;
  logic [3:0]  src_reg = '0;
  logic        dst_mode = 1'b0;
  logic [3:0]  dst_reg = '0;
  logic        byte_op = 1'b0;
  logic [15:0] pc_in = '0;
  logic        busy, done;
  logic [3:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] src_val, dst_val, dst_addr, inc_val, pc_out;
  logic        dst_is_mem, inc_en;
  logic [3:0]  inc_reg;

  logic [15:0] rf [16];
  int checks = 0;
  int errors = 0;
  int nreads = 0;

  // expected results
  logic [15:0] e_src, e_dst, e_daddr, e_ival, e_pc;
  logic        e_dmem, e_inc;
  logic [3:0]  e_ireg;
  int          e_reads;

  always #10 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];

  opd_resolver dut (
    .clk(clk), .rst(rst), .start(start), .src_mode(src_mode), .src_reg(src_reg),
    .dst_mode(dst_mode), .dst_reg(dst_reg), .byte_op(byte_op), .pc_in(pc_in),
    .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .src_val(src_val), .dst_val(dst_val),
    .dst_addr(dst_addr), .dst_is_mem(dst_is_mem), .inc_en(inc_en),
    .inc_reg(inc_reg), .inc_val(inc_val), .pc_out(pc_out)
  );

  function automatic logic [15:0] memw(input logic [15:0] a);
    logic [15:0] al;
    al = {a[15:1], 1'b0};
    memw = {al[7:0], al[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] rd(input logic [15:0] a, input logic b);
    logic [15:0] w;
    w = memw(a);
    if (!b)       rd = w;
    else if (a[0]) rd = {8'h00, w[15:8]};
    else          rd = {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] msk(input logic [15:0] v, input logic b);
    msk = b ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic model(input logic [3:0] sr, input logic [1:0] sm, input logic [3:0] dr,
                       input logic dm, input logic b, input logic [15:0] pc0);
    logic [15:0] pc, base, a, idx;
    pc = pc0; e_inc = 1'b0; e_ireg = '0; e_ival = '0; e_reads = 0;
    if (sr == 4'd3) begin
      e_src = msk((sm == 2'd3) ? 16'hFFFF : {14'd0, sm}, b);
    end else if (sr == 4'd2 && sm[1]) begin
      e_src = msk(sm[0] ? 16'd8 : 16'd4, b);
    end else if (sm == 2'd0) begin
      e_src = msk((sr == 4'd0) ? pc : rf[sr], b);
    end else if (sm == 2'd1) begin
      idx = memw(pc);
      base = (sr == 4'd0) ? pc : (sr == 4'd2) ? 16'd0 : rf[sr];
      pc = pc + 16'd2;
      a = base + idx;
      e_src = rd(a, b); e_reads = 2;
    end else if (sm == 2'd2) begin
      a = (sr == 4'd0) ? pc : rf[sr];
      e_src = rd(a, b); e_reads = 1;
    end else begin
      if (sr == 4'd0) begin
        e_src = rd(pc, b); pc = pc + 16'd2;
      end else begin
        e_src = rd(rf[sr], b);
        e_inc = 1'b1; e_ireg = sr; e_ival = rf[sr] + (b ? 16'd1 : 16'd2);
      end
      e_reads = 1;
    end
    if (dr == 4'd0)               base = pc;
    else if (e_inc && e_ireg == dr) base = e_ival;
    else                          base = rf[dr];
    if (!dm) begin
      e_dst = msk(base, b); e_daddr = '0; e_dmem = 1'b0;
    end else begin
      idx = memw(pc);
      if (dr == 4'd2) base = '0;
      pc = pc + 16'd2;
      e_daddr = base + idx;
      e_dst = rd(e_daddr, b); e_dmem = 1'b1;
      e_reads = e_reads + 2;
    end
    e_pc = pc;
  endtask

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: one-cycle request, answer after 1 to 3 cycles
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [15:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst) begin
        pend = 0;
      end else begin
        if (pend) begin
          if (cnt == 0) begin
            mem_rvalid = 1'b1; mem_rdata = memw(paddr); pend = 0;
          end else cnt--;
        end
        if (mem_req) begin
          if (pend) begin
            errors++;
            $display("FAIL R11 request while outstanding: actual 1 expected 0");
          end
          pend = 1; paddr = mem_addr; cnt = $urandom_range(0, 2); nreads++;
        end
      end
    end
  end

  task automatic run_op(input logic [3:0] sr, input logic [1:0] sm, input logic [3:0] dr,
                        input logic dm, input logic b, input logic [15:0] pc0,
                        input string tag, input bit poke);
    int t = 0;
    logic [15:0] held;
    model(sr, sm, dr, dm, b, pc0);
    @(negedge clk);
    while (busy) @(negedge clk);
    nreads = 0;
    src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr; byte_op = b; pc_in = pc0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      src_mode = 2'd0; src_reg = 4'd3; dst_mode = 1'b0; dst_reg = 4'd3;
      byte_op = ~b; pc_in = ~pc0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 1000) begin @(negedge clk); t++; end
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL R11 done never rose: actual 0 expected 1");
      return;
    end
    check(tag, "src_val", src_val, e_src);
    check(tag, "dst_val", dst_val, e_dst);
    check(tag, "dst_addr", dst_addr, e_daddr);
    check(tag, "dst_is_mem", {15'd0, dst_is_mem}, {15'd0, e_dmem});
    check(tag, "inc_en", {15'd0, inc_en}, {15'd0, e_inc});
    if (e_inc) begin
      check(tag, "inc_reg", {12'd0, inc_reg}, {12'd0, e_ireg});
      check(tag, "inc_val", inc_val, e_ival);
    end
    check(tag, "pc_out", pc_out, e_pc);
    check(tag, "reads", 16'(nreads), 16'(e_reads));
    held = src_val;
    @(negedge clk);
    check("R11", "done width", {15'd0, done}, 16'd0);
    check("R11", "held src_val", src_val, held);
  endtask

  task automatic fill_rf();
    for (int i = 0; i < 16; i++) rf[i] = 16'($urandom);
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL R11 watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_rf();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12", "busy", {15'd0, busy}, 16'd0);
    check("R12", "done", {15'd0, done}, 16'd0);
    check("R12", "mem_req", {15'd0, mem_req}, 16'd0);
    check("R12", "inc_en", {15'd0, inc_en}, 16'd0);
    check("R12", "src_val", src_val, 16'd0);
    check("R12", "pc_out", pc_out, 16'd0);

    rf[5] = 16'h2400; rf[7] = 16'h1235; rf[9] = 16'h0800;
    run_op(4'd5, 2'd0, 4'd7, 1'b0, 1'b0, 16'h4000, "R1", 0);
    run_op(4'd0, 2'd0, 4'd9, 1'b0, 1'b0, 16'h4002, "R1", 0);
    run_op(4'd5, 2'd1, 4'd7, 1'b0, 1'b0, 16'h4010, "R2", 0);
    run_op(4'd0, 2'd1, 4'd9, 1'b0, 1'b0, 16'h4020, "R2", 0);
    run_op(4'd2, 2'd1, 4'd9, 1'b0, 1'b0, 16'h4030, "R2", 0);
    run_op(4'd7, 2'd2, 4'd5, 1'b0, 1'b0, 16'h4040, "R3", 0);
    run_op(4'd7, 2'd3, 4'd9, 1'b0, 1'b0, 16'h4050, "R4", 0);
    run_op(4'd7, 2'd3, 4'd9, 1'b0, 1'b1, 16'h4050, "R4", 0);
    run_op(4'd0, 2'd3, 4'd9, 1'b0, 1'b1, 16'h4060, "R5", 0);
    run_op(4'd2, 2'd2, 4'd9, 1'b0, 1'b0, 16'h4070, "R6", 0);
    run_op(4'd2, 2'd3, 4'd9, 1'b0, 1'b0, 16'h4070, "R6", 0);
    for (int m = 0; m < 4; m++) begin
      run_op(4'd3, 2'(m), 4'd9, 1'b0, 1'b0, 16'h4080, "R7", 0);
      run_op(4'd3, 2'(m), 4'd9, 1'b0, 1'b1, 16'h4080, "R7", 0);
    end
    run_op(4'd3, 2'd1, 4'd9, 1'b1, 1'b0, 16'h4090, "R8", 0);
    run_op(4'd5, 2'd1, 4'd0, 1'b1, 1'b0, 16'h40A0, "R8", 0);
    run_op(4'd5, 2'd0, 4'd2, 1'b1, 1'b0, 16'h40B0, "R8", 0);
    run_op(4'd7, 2'd2, 4'd9, 1'b1, 1'b1, 16'h40C0, "R9", 0);
    run_op(4'd5, 2'd3, 4'd5, 1'b1, 1'b0, 16'h40D0, "R10", 0);
    run_op(4'd5, 2'd3, 4'd5, 1'b0, 1'b1, 16'h40D0, "R10", 0);
    run_op(4'd0, 2'd3, 4'd0, 1'b1, 1'b0, 16'h40E0, "R10", 0);
    run_op(4'd5, 2'd1, 4'd9, 1'b1, 1'b0, 16'h40F0, "R11", 1);

    for (int n = 0; n < 300; n++) begin
      fill_rf();
      run_op(4'($urandom), 2'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), "R9", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule